// File: doc/BRIEF.md
# Byte-Sliced Registered Bus Transceiver

This block joins two 16-bit data ports, A and B, and moves data between them either straight through or from a pair of holding registers. The data path is cut into two 8-bit lanes that are controlled entirely apart from each other. Wiring both lanes' controls to the same nets turns the block into one 16-bit transceiver.

Each lane has these controls:

- **Holding registers.** There is one register fed from port A and one fed from port B. Each register is loaded by its own capture strobe.
- **Source select.** For each direction, a select line chooses what drives the far port: the live value from the opposite port, or the value held in that direction's register.
- **Output enables.** The enable for the A-to-B direction is active high. The enable for the B-to-A direction is active low.

Both registers keep loading and holding while a lane has both of its outputs off.

Pins that would be three-state are modelled as a separate input vector, output vector and per-lane output-enable vector for each port. Capture strobes are level signals that share the system clock. A register loads in the system clock cycle in which its strobe is first seen high.

Per lane, the two enables pick one of four drive modes:

| Mode | B-side enable | A-side control | Ports driven |
|------|---------------|----------------|--------------|
| `DIR_ISOLATE` | low | high | neither |
| `DIR_A_TO_B` | high | high | B only |
| `DIR_B_TO_A` | low | low | A only |
| `DIR_BOTH` | high | low | both |

Moving from one mode to another takes effect in the same cycle as the enable change. The block holds no control state besides the edge detectors and the data registers.

Top module: `xcv_transceiver`

## Requirements
- R1: A synchronous active-high reset clears all four holding registers to zero.
- R2: In the system clock cycle where a lane's A strobe (`a_cap_clk`) first reads high, that lane's A register loads the resolved A value. The stored value is visible on the B output from the next cycle.
- R3: In the system clock cycle where a lane's B strobe (`b_cap_clk`) first reads high, that lane's B register loads the resolved B value. The stored value is visible on the A output from the next cycle.
- R4: Each lane's B output enable equals `ab_drive` for that lane (active high). Each lane's A output enable equals the inverse of `ba_drive_n` for that lane (active low).
- R5: The B output of a lane depends on `ab_sel_stored`. When the select is high, the output is the lane's A register. When it is low and port A is not driven, the output is the live A input.
- R6: The A output of a lane depends on `ba_sel_stored`. When the select is high, the output is the lane's B register. When it is low and port B is not driven, the output is the live B input.
- R7: With both of a lane's outputs off, both output enables are low and both registers still load on their strobes.
- R8: With only B driven and the B output taking live A, strobing both registers loads the A input into both. The mirror case, with only A driven and live B selected, loads the B input into both.
- R9: With both directions driven, each output can carry its own stored value at the same time, so the two registers exchange their values across the ports.
- R10: With both directions driven and both selects on live data, each port's output equals that port's own input, so each pin reinforces its input.
- R11: A strobe held high loads only once, and its falling edge loads nothing.
- R12: A strobe, select or enable on one lane never changes the other lane's outputs or registers.
- R13: The resolved value a register loads is the port's driven output when that port is enabled, and its external input otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Value arriving on port A |
| a_out | output | 16 | Value driven onto port A |
| a_oe | output | 2 | Per-lane output enable for port A |
| b_in | input | 16 | Value arriving on port B |
| b_out | output | 16 | Value driven onto port B |
| b_oe | output | 2 | Per-lane output enable for port B |
| a_cap_clk | input | 2 | Per-lane strobe that loads the A register |
| b_cap_clk | input | 2 | Per-lane strobe that loads the B register |
| ab_sel_stored | input | 2 | Per-lane select: 1 puts the stored A register on B |
| ba_sel_stored | input | 2 | Per-lane select: 1 puts the stored B register on A |
| ab_drive | input | 2 | Per-lane B output enable, active high |
| ba_drive_n | input | 2 | Per-lane A output enable, active low |

## Verification
The bench builds the block with its default parameters: two lanes of eight bits each. Two lanes are enough to check that strobes and enables on one lane leave the other untouched. Tying both lanes' controls together exercises the full 16-bit path. With eight bits per lane, distinct patterns can be loaded into each register, which separates live data from stored data in every drive mode.

// File: rtl/xcv_pkg.sv
package xcv_pkg;
    // bit 1: B side driven, bit 0: A side driven
    typedef enum logic [1:0] {
        DIR_ISOLATE = 2'b00,
        DIR_B_TO_A  = 2'b01,
        DIR_A_TO_B  = 2'b10,
        DIR_BOTH    = 2'b11
    } dir_mode_e;
endpackage

// File: rtl/xcv_edge_strobe.sv
module xcv_edge_strobe #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] level_q;

    // During reset the history tracks the level, so a strobe already high
    // at reset release does not count as a new edge.
    always_ff @(posedge clk) begin
        level_q <= level;
    end

    assign rise = rst ? '0 : (level & ~level_q);
endmodule

// File: rtl/xcv_byte_lane.sv
module xcv_byte_lane
    import xcv_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] a_in,
    input  logic [BW-1:0] b_in,
    input  logic          cap_a,
    input  logic          cap_b,
    input  logic          sel_a_stored,
    input  logic          sel_b_stored,
    input  logic          drive_b,
    input  logic          drive_a_n,
    output logic [BW-1:0] a_out,
    output logic          a_oe,
    output logic [BW-1:0] b_out,
    output logic          b_oe
);
    dir_mode_e     mode;
    logic [BW-1:0] reg_a;
    logic [BW-1:0] reg_b;
    logic [BW-1:0] a_res;
    logic [BW-1:0] b_res;

    assign mode = dir_mode_e'({drive_b, ~drive_a_n});

    always_comb begin
        unique case (mode)
            DIR_ISOLATE: begin a_oe = 1'b0; b_oe = 1'b0; end
            DIR_B_TO_A:  begin a_oe = 1'b1; b_oe = 1'b0; end
            DIR_A_TO_B:  begin a_oe = 1'b0; b_oe = 1'b1; end
            DIR_BOTH:    begin a_oe = 1'b1; b_oe = 1'b1; end
            default:     begin a_oe = 1'b0; b_oe = 1'b0; end
        endcase
    end

    // The live path through a driven far port is resolved without a
    // combinational loop: when both sides pass live data, each pin holds
    // its own input value.
    always_comb begin
        if (sel_b_stored)      a_out = reg_b;
        else if (!b_oe)        a_out = b_in;
        else if (sel_a_stored) a_out = reg_a;
        else                   a_out = a_in;

        if (sel_a_stored)      b_out = reg_a;
        else if (!a_oe)        b_out = a_in;
        else if (sel_b_stored) b_out = reg_b;
        else                   b_out = b_in;
    end

    assign a_res = a_oe ? a_out : a_in;
    assign b_res = b_oe ? b_out : b_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_a <= '0;
            reg_b <= '0;
        end else begin
            if (cap_a) reg_a <= a_res;
            if (cap_b) reg_b <= b_res;
        end
    end
endmodule

// File: rtl/xcv_transceiver.sv
module xcv_transceiver #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES*LANE_W-1:0] a_in,
    output logic [LANES*LANE_W-1:0] a_out,
    output logic [LANES-1:0]        a_oe,
    input  logic [LANES*LANE_W-1:0] b_in,
    output logic [LANES*LANE_W-1:0] b_out,
    output logic [LANES-1:0]        b_oe,
    input  logic [LANES-1:0]        a_cap_clk,
    input  logic [LANES-1:0]        b_cap_clk,
    input  logic [LANES-1:0]        ab_sel_stored,
    input  logic [LANES-1:0]        ba_sel_stored,
    input  logic [LANES-1:0]        ab_drive,
    input  logic [LANES-1:0]        ba_drive_n
);
    logic [LANES-1:0] cab_rise;
    logic [LANES-1:0] cba_rise;

    xcv_edge_strobe #(.W(LANES)) u_cab_edge (
        .clk(clk), .rst(rst), .level(a_cap_clk), .rise(cab_rise)
    );

    xcv_edge_strobe #(.W(LANES)) u_cba_edge (
        .clk(clk), .rst(rst), .level(b_cap_clk), .rise(cba_rise)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        xcv_byte_lane #(.BW(LANE_W)) u_lane (
            .clk         (clk),
            .rst         (rst),
            .a_in        (a_in[l*LANE_W +: LANE_W]),
            .b_in        (b_in[l*LANE_W +: LANE_W]),
            .cap_a       (cab_rise[l]),
            .cap_b       (cba_rise[l]),
            .sel_a_stored(ab_sel_stored[l]),
            .sel_b_stored(ba_sel_stored[l]),
            .drive_b     (ab_drive[l]),
            .drive_a_n   (ba_drive_n[l]),
            .a_out       (a_out[l*LANE_W +: LANE_W]),
            .a_oe        (a_oe[l]),
            .b_out       (b_out[l*LANE_W +: LANE_W]),
            .b_oe        (b_oe[l])
        );
    end
endmodule

// File: rtl/xcv_transceiver_chk.sv
module xcv_transceiver_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic [LANES*LANE_W-1:0] a_in,
    input logic [LANES*LANE_W-1:0] a_out,
    input logic [LANES-1:0]        a_oe,
    input logic [LANES*LANE_W-1:0] b_in,
    input logic [LANES*LANE_W-1:0] b_out,
    input logic [LANES-1:0]        b_oe,
    input logic [LANES-1:0]        ab_sel_stored,
    input logic [LANES-1:0]        ba_sel_stored,
    input logic [LANES-1:0]        ab_drive,
    input logic [LANES-1:0]        ba_drive_n,
    input logic [LANES-1:0]        cab_rise,
    input logic [LANES-1:0]        cba_rise
);
    p_oe_polarity_r4: assert property (@(posedge clk) disable iff (rst)
        (a_oe == ~ba_drive_n) && (b_oe == ab_drive));

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        p_live_ab_r5: assert property (@(posedge clk) disable iff (rst)
            (!ab_sel_stored[l] && !a_oe[l])
            |-> b_out[l*LANE_W +: LANE_W] == a_in[l*LANE_W +: LANE_W]);

        p_live_ba_r6: assert property (@(posedge clk) disable iff (rst)
            (!ba_sel_stored[l] && !b_oe[l])
            |-> a_out[l*LANE_W +: LANE_W] == b_in[l*LANE_W +: LANE_W]);

        p_cap_a_r2: assert property (@(posedge clk) disable iff (rst)
            (cab_rise[l] && !a_oe[l])
            |=> (!ab_sel_stored[l] ||
                 b_out[l*LANE_W +: LANE_W] == $past(a_in[l*LANE_W +: LANE_W])));

        p_cap_b_r3: assert property (@(posedge clk) disable iff (rst)
            (cba_rise[l] && !b_oe[l])
            |=> (!ba_sel_stored[l] ||
                 a_out[l*LANE_W +: LANE_W] == $past(b_in[l*LANE_W +: LANE_W])));

        p_hold_a_r11: assert property (@(posedge clk) disable iff (rst)
            (!cab_rise[l] && ab_sel_stored[l])
            |=> (!ab_sel_stored[l] || $stable(b_out[l*LANE_W +: LANE_W])));

        p_hold_b_r11: assert property (@(posedge clk) disable iff (rst)
            (!cba_rise[l] && ba_sel_stored[l])
            |=> (!ba_sel_stored[l] || $stable(a_out[l*LANE_W +: LANE_W])));
    end
endmodule

bind xcv_transceiver xcv_transceiver_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .a_in         (a_in),
    .a_out        (a_out),
    .a_oe         (a_oe),
    .b_in         (b_in),
    .b_out        (b_out),
    .b_oe         (b_oe),
    .ab_sel_stored(ab_sel_stored),
    .ba_sel_stored(ba_sel_stored),
    .ab_drive     (ab_drive),
    .ba_drive_n   (ba_drive_n),
    .cab_rise     (cab_rise),
    .cba_rise     (cba_rise)
);

// File: tb/xcv_transceiver_tb.sv
module xcv_transceiver_tb;
    localparam int PERIOD = 10;
    localparam int Q      = PERIOD / 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] a_in, b_in;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_oe, b_oe;
    logic [1:0]  cab, cba, sab, sba, oeab, oeba_n;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    xcv_transceiver u_dut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .a_cap_clk(cab), .b_cap_clk(cba),
        .ab_sel_stored(sab), .ba_sel_stored(sba),
        .ab_drive(oeab), .ba_drive_n(oeba_n)
    );

    // Lane 0 rows, lane 0 registers preloaded A=3C, B=C3.
    // {oeab, oeba_n, sab, sba, a_in, b_in, exp a_out, exp a_oe, exp b_out, exp b_oe}
    localparam logic [37:0] TBL [10] = '{
        {4'b0100, 8'h11, 8'h22, 8'h22, 1'b0, 8'h11, 1'b0},
        {4'b1100, 8'h5A, 8'h00, 8'h5A, 1'b0, 8'h5A, 1'b1},
        {4'b1110, 8'h5A, 8'h00, 8'h3C, 1'b0, 8'h3C, 1'b1},
        {4'b0000, 8'h00, 8'hA5, 8'hA5, 1'b1, 8'hA5, 1'b0},
        {4'b0001, 8'h00, 8'hA5, 8'hC3, 1'b1, 8'hC3, 1'b0},
        {4'b1011, 8'h00, 8'h00, 8'hC3, 1'b1, 8'h3C, 1'b1},
        {4'b1000, 8'h96, 8'h69, 8'h96, 1'b1, 8'h69, 1'b1},
        {4'b1010, 8'h96, 8'h69, 8'h3C, 1'b1, 8'h3C, 1'b1},
        {4'b1001, 8'h96, 8'h69, 8'hC3, 1'b1, 8'hC3, 1'b1},
        {4'b1100, 8'hFF, 8'h01, 8'hFF, 1'b0, 8'hFF, 1'b1}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input logic [1:0] e_ab, input logic [1:0] e_ba_n,
                           input logic [1:0] s_ab, input logic [1:0] s_ba);
        oeab = e_ab; oeba_n = e_ba_n; sab = s_ab; sba = s_ba;
    endtask

    task automatic pulse(input logic [1:0] ca, input logic [1:0] cb);
        @(negedge clk); cab = ca; cba = cb;
        @(negedge clk); cab = 2'b00; cba = 2'b00;
    endtask

    initial begin
        #(PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; a_in = '0; b_in = '0; cab = '0; cba = '0;
        set_ctl(2'b00, 2'b11, 2'b00, 2'b00);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset contents on both lanes
        @(negedge clk); set_ctl(2'b11, 2'b00, 2'b11, 2'b11);
        #Q;
        chk("R1 stored A after reset", b_out, 16'h0000);
        chk("R1 stored B after reset", a_out, 16'h0000);

        // R7 / R2 / R3: load in isolation
        @(negedge clk); set_ctl(2'b00, 2'b11, 2'b00, 2'b00);
        a_in = 16'h003C; b_in = 16'h00C3;
        #Q;
        chk("R7 oe off in isolation", {14'd0, a_oe}, 16'h0000);
        chk("R7 oe off in isolation B", {14'd0, b_oe}, 16'h0000);
        pulse(2'b01, 2'b01);
        set_ctl(2'b01, 2'b10, 2'b01, 2'b01);
        #Q;
        chk("R2 A register loaded", b_out, 16'h003C);
        chk("R3 B register loaded", a_out, 16'h00C3);

        // Table: lane 0 modes, lane 1 isolated (R4 R5 R6 R9 R10 R12)
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            set_ctl({1'b0, TBL[i][37]}, {1'b1, TBL[i][36]}, {1'b0, TBL[i][35]}, {1'b0, TBL[i][34]});
            a_in = {8'h00, TBL[i][33:26]};
            b_in = {8'h00, TBL[i][25:18]};
            #Q;
            chk($sformatf("R5/R6/R9/R10 row %0d a_out", i), a_out, {8'h00, TBL[i][17:10]});
            chk($sformatf("R5/R6/R9/R10 row %0d b_out", i), b_out, {8'h00, TBL[i][8:1]});
            chk($sformatf("R4 row %0d oe", i), {14'd0, a_oe[0], b_oe[0]}, {14'd0, TBL[i][9], TBL[i][0]});
            chk($sformatf("R12 row %0d lane1 oe", i), {14'd0, a_oe[1], b_oe[1]}, 16'h0000);
        end

        // R11: held strobe loads once, falling edge loads nothing
        @(negedge clk); set_ctl(2'b00, 2'b11, 2'b00, 2'b00); a_in = 16'h0077;
        @(negedge clk); cab = 2'b01;
        @(negedge clk); a_in = 16'h0088;
        repeat (3) @(negedge clk);
        a_in = 16'h0099; cab = 2'b00;
        @(negedge clk); set_ctl(2'b01, 2'b11, 2'b01, 2'b00);
        #Q;
        chk("R11 single load on held strobe", b_out, 16'h0077);

        // R8: A into both registers
        @(negedge clk); set_ctl(2'b01, 2'b11, 2'b00, 2'b00); a_in = 16'h004E; b_in = 16'h0000;
        pulse(2'b01, 2'b01);
        set_ctl(2'b01, 2'b10, 2'b01, 2'b01);
        #Q;
        chk("R8 A into B register", a_out, 16'h004E);
        chk("R8 A into A register", b_out, 16'h004E);

        // R8 mirror: B into both registers
        @(negedge clk); set_ctl(2'b00, 2'b10, 2'b00, 2'b00); a_in = 16'h0000; b_in = 16'h00E4;
        pulse(2'b01, 2'b01);
        set_ctl(2'b01, 2'b10, 2'b01, 2'b01);
        #Q;
        chk("R8 B into B register", a_out, 16'h00E4);
        chk("R8 B into A register", b_out, 16'h00E4);

        // R13: driven port loads its driven value
        @(negedge clk); set_ctl(2'b00, 2'b11, 2'b00, 2'b00); b_in = 16'h00D2;
        pulse(2'b00, 2'b01);
        set_ctl(2'b00, 2'b10, 2'b00, 2'b01); a_in = 16'h0000; b_in = 16'h0000;
        pulse(2'b01, 2'b00);
        set_ctl(2'b01, 2'b11, 2'b01, 2'b00);
        #Q;
        chk("R13 A register took driven value", b_out, 16'h00D2);

        // R12: lane 1 activity leaves lane 0 intact
        @(negedge clk); set_ctl(2'b00, 2'b11, 2'b00, 2'b00);
        a_in = 16'hAB00; b_in = 16'hCD00;
        pulse(2'b10, 2'b10);
        set_ctl(2'b11, 2'b00, 2'b11, 2'b11);
        #Q;
        chk("R12 lane split stored A", b_out, 16'hABD2);
        chk("R12 lane split stored B", a_out, 16'hCDD2);

        // R5 / R4: controls tied for full width live transfer
        @(negedge clk); set_ctl(2'b11, 2'b11, 2'b00, 2'b00);
        a_in = 16'h1234; b_in = 16'h0000;
        #Q;
        chk("R5 full width live A to B", b_out, 16'h1234);
        chk("R4 full width enables", {12'd0, a_oe, b_oe}, 16'h0003);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule